// File: doc/BRIEF.md
# Four-Mode Serial Port with Register Access

This block is a full-duplex serial port in the style of small microcontroller peripherals. Software reaches it through two byte-wide registers. The control register selects the mode and holds the flags. A write to the data register starts a transmission. A read of the data register returns the last accepted received byte, which is stored in a holding register separate from the transmit shifter. Reception is double buffered. A second frame can arrive while the first byte is still unread. If the second frame completes first, it replaces the unread byte.

There are four modes. Mode 0 is a synchronous shift register clocked at core clock / 2. Mode 1 is an 8-bit asynchronous UART timed by an external baud tick. Mode 2 is a 9-bit UART at a fixed core clock / 64, or / 32 when the rate-doubling input is high. Mode 3 is a 9-bit UART timed by the baud tick. The asynchronous modes use 16 oversamples per bit and take each bit as the majority of three samples at the bit centre. In the 9-bit modes the ninth bit can filter addresses between several processors.

The transmitter FSM has the states TX_IDLE, TX_SHIFT, TX_START, TX_DATA, TX_NINTH and TX_STOP, with these transitions:
- A data write leads from any state to TX_SHIFT in mode 0, or to TX_START otherwise.
- TX_START goes to TX_DATA at the end of the start bit.
- TX_DATA goes to TX_NINTH in modes 2 and 3, or to TX_STOP in mode 1, after the eighth bit.
- TX_NINTH goes to TX_STOP.
- TX_STOP returns to TX_IDLE at the end of the stop bit.
- TX_SHIFT returns to TX_IDLE after eight clock periods.

The receiver FSM has the states RX_IDLE, RX_SHIFT, RX_START, RX_DATA, RX_NINTH and RX_STOP, with these transitions:
- RX_IDLE goes to RX_SHIFT in mode 0 when reception is enabled and RI is clear.
- RX_IDLE goes to RX_START when a low level is seen on the line.
- RX_START falls back to RX_IDLE if the mid-bit vote is high. Otherwise it goes to RX_DATA.
- RX_DATA goes to RX_NINTH or RX_STOP.
- RX_NINTH goes to RX_STOP.
- RX_STOP returns to RX_IDLE at mid-stop.
- RX_SHIFT returns to RX_IDLE after eight bits.

Top module: `sio_port`

## Requirements
- R1: After reset, the control register reads 00h, `irq` is 0, `txd_out` is 1 and `rxd_oe` is 0.
- R2: Register map. Address 0 is the control register, with bit 7 = mode high, bit 6 = mode low, bit 5 = filter enable, bit 4 = receive enable, bit 3 = transmit ninth bit, bit 2 = received ninth bit, bit 1 = TI, bit 0 = RI. Address 1 is the data register. Read data appears on `reg_rdata` in the cycle after the `reg_rd` strobe.
- R3: In mode 1 and mode 3, one bit lasts 16 `baud_tick` pulses. In mode 2, one bit lasts 64 core clocks, or 32 core clocks when `dbl_rate` is high.
- R4: An asynchronous frame on `txd_out` is a 0 start bit, then the 8 data bits LSB first, then the TB8 bit in modes 2 and 3 only, then a 1 stop bit.
- R5: In the asynchronous modes, TI is set when the stop bit begins, and not before.
- R6: An accepted asynchronous frame loads the received byte and sets RI by mid-stop. RB8 takes the ninth bit in modes 2 and 3, and the stop bit in mode 1.
- R7: A completed frame overwrites an unread byte, so a read returns the latest byte.
- R8: With the filter bit set, a frame is discarded in mode 1 if its stop bit is 0, and in modes 2 and 3 if its ninth bit is 0. A discarded frame changes neither RI nor RB8 nor the data register.
- R9: With REN = 0, no frame is received.
- R10: In mode 0, a data write shifts the byte out LSB first on `rxd_out`, with `rxd_oe` high. Each bit is valid while `txd_out` rises (low half, then high half of each bit). TI is set after the eighth bit.
- R11: In mode 0, with REN = 1 and RI = 0, the block clocks in 8 bits from `rxd_in` LSB first. Each bit is sampled at the end of the high half of `txd_out`. The block then loads the byte, sets RI and clears RB8.
- R12: `irq` equals TI OR RI. Writes to the control register may set or clear either flag. The hardware only ever sets them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 data |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, registered |
| baud_tick | input | 1 | Oversample tick for modes 1 and 3 |
| dbl_rate | input | 1 | Mode 2 rate select: 1 gives /32, 0 gives /64 |
| rxd_in | input | 1 | Receive pin input |
| rxd_out | output | 1 | Receive pin drive value in mode 0 |
| rxd_oe | output | 1 | Receive pin drive enable |
| txd_out | output | 1 | Serial data, or the shift clock in mode 0 |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the points where the flags are set:
- TI is checked low in the last data bit and high in the stop bit. A design that set it at the end of the frame, or one bit early, fails one of these two samples.
- Frames are rejected by a bad stop bit in mode 1 and by a zero ninth bit in mode 3. A design that still loaded the byte or updated RB8 on a rejected frame shows a changed data register or control value.
- Two frames are sent back to back without a read. This catches a design that refuses to overwrite the unread byte.
- Mode 2 is run at both divider settings, and mode 1 with a sparse baud tick. This exposes a wrong bit length.
- In mode 0, each bit is sampled against the shift clock edge. This exposes wrong bit order or a wrong clock phase.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_8VAR  = 2'b01,
        MODE_9FIX  = 2'b10,
        MODE_9VAR  = 2'b11
    } mode_t;

    localparam int B_MHI  = 7;
    localparam int B_MLO  = 6;
    localparam int B_FILT = 5;
    localparam int B_REN  = 4;
    localparam int B_TB8  = 3;
    localparam int B_RB8  = 2;
    localparam int B_TI   = 1;
    localparam int B_RI   = 0;

    localparam int OS_RATE = 16;
    localparam int OS_W    = $clog2(OS_RATE);
    localparam logic [OS_W-1:0] OS_MID  = OS_W'(OS_RATE/2 + 1);
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

    function automatic logic is_nine(mode_t m);
        return (m == MODE_9FIX) || (m == MODE_9VAR);
    endfunction
endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic          os_tick,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          tb8,
    output logic          line,
    output logic          sclk,
    output logic          dq,
    output logic          oe,
    output logic          busy,
    output logic          ti_set
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_SHIFT, TX_START, TX_DATA, TX_NINTH, TX_STOP
    } tx_st_t;

    tx_st_t          st;
    logic [DW-1:0]   sh;
    logic            b9;
    logic [CW-1:0]   idx;
    logic [OS_W-1:0] cnt;
    logic            ph;
    logic            bit_end;

    assign bit_end = os_tick && (cnt == OS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_IDLE; sh <= '0; b9 <= 1'b0; idx <= '0; cnt <= '0; ph <= 1'b0;
        end else if (load) begin
            sh <= din; b9 <= tb8; idx <= '0; cnt <= '0; ph <= 1'b0;
            st <= (mode == MODE_SHIFT) ? TX_SHIFT : TX_START;
        end else begin
            if (os_tick) cnt <= cnt + 1'b1;
            unique case (st)
                TX_IDLE: ;
                TX_SHIFT: begin
                    ph <= ~ph;
                    if (ph) begin
                        sh  <= sh >> 1;
                        idx <= idx + 1'b1;
                        if (idx == LAST) st <= TX_IDLE;
                    end
                end
                TX_START: if (bit_end) st <= TX_DATA;
                TX_DATA: if (bit_end) begin
                    sh  <= sh >> 1;
                    idx <= idx + 1'b1;
                    if (idx == LAST) st <= is_nine(mode) ? TX_NINTH : TX_STOP;
                end
                TX_NINTH: if (bit_end) st <= TX_STOP;
                TX_STOP:  if (bit_end) st <= TX_IDLE;
                default:  st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        line   = 1'b1;
        sclk   = 1'b1;
        oe     = 1'b0;
        busy   = (st != TX_IDLE);
        dq     = sh[0];
        ti_set = 1'b0;
        unique case (st)
            TX_IDLE:  ;
            TX_SHIFT: begin
                sclk   = ph;
                oe     = 1'b1;
                ti_set = !load && ph && (idx == LAST);
            end
            TX_START: line = 1'b0;
            TX_DATA: begin
                line   = sh[0];
                ti_set = !load && bit_end && (idx == LAST) && !is_nine(mode);
            end
            TX_NINTH: begin
                line   = b9;
                ti_set = !load && bit_end;
            end
            TX_STOP:  ;
            default:  ;
        endcase
    end

    // R5
    ti_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ti_set |=> (st == TX_STOP || st == TX_IDLE));

    // R10
    shift_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TX_SHIFT && !load) |=> (oe || st == TX_IDLE));
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_t         mode,
    input  logic          os_tick,
    input  logic          ren,
    input  logic          filt,
    input  logic          ri,
    input  logic          tx_busy,
    input  logic          rxd,
    output logic          sclk,
    output logic          busy,
    output logic          done,
    output logic          ok,
    output logic [DW-1:0] data,
    output logic          b8
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_SHIFT, RX_START, RX_DATA, RX_NINTH, RX_STOP
    } rx_st_t;

    rx_st_t          st;
    logic [DW-1:0]   sh;
    logic            b9, s0, s1, ph;
    logic [CW-1:0]   idx;
    logic [OS_W-1:0] cnt;
    logic            vote, mid, bend;

    assign vote = (s0 & s1) | (s0 & rxd) | (s1 & rxd);
    assign mid  = os_tick && (cnt == OS_MID);
    assign bend = os_tick && (cnt == OS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_IDLE; sh <= '0; b9 <= 1'b0; s0 <= 1'b1; s1 <= 1'b1;
            ph <= 1'b0; idx <= '0; cnt <= '0;
        end else begin
            if (os_tick && st != RX_IDLE) begin
                cnt <= cnt + 1'b1;
                if (cnt == OS_MID - 2) s0 <= rxd;
                if (cnt == OS_MID - 1) s1 <= rxd;
            end
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0; idx <= '0; ph <= 1'b0;
                    if (mode == MODE_SHIFT) begin
                        if (ren && !ri && !tx_busy) st <= RX_SHIFT;
                    end else if (ren && !rxd) begin
                        st <= RX_START;
                    end
                end
                RX_SHIFT: begin
                    ph <= ~ph;
                    if (ph) begin
                        sh  <= {rxd, sh[DW-1:1]};
                        idx <= idx + 1'b1;
                        if (idx == LAST) st <= RX_IDLE;
                    end
                end
                RX_START: begin
                    if (mid && vote)  st <= RX_IDLE;
                    else if (bend)    st <= RX_DATA;
                end
                RX_DATA: begin
                    if (mid) sh <= {vote, sh[DW-1:1]};
                    if (bend) begin
                        idx <= idx + 1'b1;
                        if (idx == LAST) st <= is_nine(mode) ? RX_NINTH : RX_STOP;
                    end
                end
                RX_NINTH: begin
                    if (mid)  b9 <= vote;
                    if (bend) st <= RX_STOP;
                end
                RX_STOP: if (mid) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        sclk = (st == RX_SHIFT) ? ph : 1'b1;
        busy = (st != RX_IDLE);
        done = 1'b0;
        ok   = 1'b1;
        data = sh;
        b8   = 1'b0;
        unique case (st)
            RX_SHIFT: begin
                done = ph && (idx == LAST);
                data = {rxd, sh[DW-1:1]};
            end
            RX_STOP: begin
                done = mid;
                b8   = is_nine(mode) ? b9 : vote;
                ok   = !filt || b8;
            end
            default: ;
        endcase
    end

    // R9
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE && !ren) |=> (st == RX_IDLE));

    // R6
    rx_done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (st == RX_IDLE));
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DW     = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              baud_tick,
    input  logic              dbl_rate,
    input  logic              rxd_in,
    output logic              rxd_out,
    output logic              rxd_oe,
    output logic              txd_out,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);

    logic [DW-1:0] ctrl_q, rxbuf_q;
    logic [1:0]    div_q;
    logic          os_tick;
    mode_t         mode;
    logic          tx_line, tx_sclk, tx_busy, ti_set;
    logic          rx_sclk, rx_busy, rx_done, rx_ok, rx_b8;
    logic [DW-1:0] rx_data;
    logic          wr_ctrl;

    assign mode    = mode_t'({ctrl_q[B_MHI], ctrl_q[B_MLO]});
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign os_tick = (mode == MODE_9FIX) ? (dbl_rate ? div_q[0] : (div_q == 2'b11))
                                         : baud_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0; rxbuf_q <= '0; reg_rdata <= '0; div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
            if (wr_ctrl) ctrl_q <= reg_wdata;
            if (ti_set)  ctrl_q[B_TI] <= 1'b1;
            if (rx_done && rx_ok) begin
                ctrl_q[B_RI]  <= 1'b1;
                ctrl_q[B_RB8] <= rx_b8;
                rxbuf_q       <= rx_data;
            end
            if (reg_rd) reg_rdata <= (reg_addr == A_DATA) ? rxbuf_q : ctrl_q;
        end
    end

    sio_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
        .load(reg_wr && (reg_addr == A_DATA)), .din(reg_wdata), .tb8(ctrl_q[B_TB8]),
        .line(tx_line), .sclk(tx_sclk), .dq(rxd_out), .oe(rxd_oe),
        .busy(tx_busy), .ti_set(ti_set)
    );

    sio_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
        .ren(ctrl_q[B_REN]), .filt(ctrl_q[B_FILT]), .ri(ctrl_q[B_RI]),
        .tx_busy(tx_busy), .rxd(rxd_in), .sclk(rx_sclk), .busy(rx_busy),
        .done(rx_done), .ok(rx_ok), .data(rx_data), .b8(rx_b8)
    );

    always_comb begin
        if (mode == MODE_SHIFT)
            txd_out = tx_busy ? tx_sclk : (rx_busy ? rx_sclk : 1'b1);
        else
            txd_out = tx_line;
        irq = ctrl_q[B_TI] | ctrl_q[B_RI];
    end

    // R12
    ti_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_TI] && !wr_ctrl) |=> ctrl_q[B_TI]);

    // R6
    ri_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ok) |=> (ctrl_q[B_RI] && rxbuf_q == $past(rx_data)));

    // R8
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_ok) |=> $stable(rxbuf_q));
endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [0:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       baud_tick = 1'b0, dbl_rate = 1'b0, rxd_in = 1'b1;
    logic       rxd_out, rxd_oe, txd_out, irq;

    int  checks = 0, fails = 0, tick_div = 1, tcnt = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        tcnt      = (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        baud_tick = (tcnt == 0);
    end

    sio_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .baud_tick(baud_tick), .dbl_rate(dbl_rate), .rxd_in(rxd_in),
        .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd_out(txd_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Send a byte and check the frame bit by bit at bit centres (R3 R4 R5)
    task automatic tx_expect(input logic [7:0] d, input bit nine, input bit b9,
                             input int bl, input string req);
        logic [10:0] fr;
        int n;
        n = nine ? 11 : 10;
        fr = '1;
        fr[0] = 1'b0;
        fr[8:1] = d;
        if (nine) fr[9] = b9;
        wr(1'b1, d);
        while (txd_out !== 1'b0) @(negedge clk);
        repeat (bl/2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            chk(req, {7'd0, txd_out}, {7'd0, fr[i]});
            if (i == n-2) chk("R5 TI low before stop", {7'd0, irq}, 8'd0);
            if (i == n-1) chk("R5 TI set in stop", {7'd0, irq}, 8'd1);
            repeat (bl) @(negedge clk);
        end
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit nine, input bit b9,
                            input bit stopv, input int bl);
        rxd_in = 1'b0; repeat (bl) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd_in = d[i]; repeat (bl) @(negedge clk); end
        if (nine) begin rxd_in = b9; repeat (bl) @(negedge clk); end
        rxd_in = stopv; repeat (bl) @(negedge clk);
        rxd_in = 1'b1; repeat (2*bl) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD*WD_CYCLES);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete (all requirements)");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 txd", {7'd0, txd_out}, 8'd1);
        chk("R1 oe", {7'd0, rxd_oe}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(1'b0, 8'h00, "R1 R2 ctrl after reset");

        // Mode 1 transmit, tick every clock
        wr(1'b0, 8'h40);
        tx_expect(8'hA5, 1'b0, 1'b0, 16, "R4 mode1 tx bit");
        rd_chk(1'b0, 8'h42, "R5 TI in ctrl");

        // R12 software sets and clears flags
        wr(1'b0, 8'h41);
        chk("R12 irq by sw set RI", {7'd0, irq}, 8'd1);
        wr(1'b0, 8'h50);
        chk("R12 irq after sw clear", {7'd0, irq}, 8'd0);

        // R6 mode 1 receive
        rx_frame(8'h3C, 1'b0, 1'b0, 1'b1, 16);
        rd_chk(1'b0, 8'h55, "R6 ctrl RI RB8 mode1");
        rd_chk(1'b1, 8'h3C, "R6 data mode1");

        // R7 overrun
        rx_frame(8'h11, 1'b0, 1'b0, 1'b1, 16);
        rx_frame(8'h22, 1'b0, 1'b0, 1'b1, 16);
        rd_chk(1'b1, 8'h22, "R7 overwrite");

        // R8 filter, mode 1 bad stop discarded, good stop kept
        wr(1'b0, 8'h70);
        rx_frame(8'h44, 1'b0, 1'b0, 1'b0, 16);
        rd_chk(1'b0, 8'h70, "R8 bad stop ctrl");
        rd_chk(1'b1, 8'h22, "R8 bad stop data");
        rx_frame(8'h45, 1'b0, 1'b0, 1'b1, 16);
        rd_chk(1'b0, 8'h75, "R8 good stop ctrl");
        rd_chk(1'b1, 8'h45, "R8 good stop data");

        // R9 receive disabled
        wr(1'b0, 8'h40);
        rx_frame(8'h77, 1'b0, 1'b0, 1'b1, 16);
        rd_chk(1'b0, 8'h40, "R9 ctrl with REN=0");
        rd_chk(1'b1, 8'h45, "R9 data with REN=0");

        // R3 mode 1 with a tick every third clock
        tick_div = 3;
        tx_expect(8'h96, 1'b0, 1'b0, 48, "R3 mode1 sparse tick");
        tick_div = 1;

        // Mode 3: ninth bit transmit and address filter
        wr(1'b0, 8'hF8);
        tx_expect(8'h5A, 1'b1, 1'b1, 16, "R4 mode3 tx bit");
        rd_chk(1'b0, 8'hFA, "R5 TI mode3");
        wr(1'b0, 8'hF0);
        rx_frame(8'h99, 1'b1, 1'b0, 1'b1, 16);
        rd_chk(1'b0, 8'hF0, "R8 ninth=0 ctrl");
        rd_chk(1'b1, 8'h45, "R8 ninth=0 data");
        rx_frame(8'h66, 1'b1, 1'b1, 1'b1, 16);
        rd_chk(1'b0, 8'hF5, "R6 ninth=1 ctrl");
        rd_chk(1'b1, 8'h66, "R6 ninth=1 data");

        // Mode 2: fixed rate, both divider settings
        wr(1'b0, 8'h80);
        dbl_rate = 1'b0;
        tx_expect(8'h0F, 1'b1, 1'b0, 64, "R3 mode2 /64");
        wr(1'b0, 8'h80);
        dbl_rate = 1'b1;
        tx_expect(8'hF0, 1'b1, 1'b0, 32, "R3 mode2 /32");

        // R10 mode 0 transmit
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hC3);
        for (int i = 0; i < 8; i++) begin
            while (txd_out !== 1'b0) @(negedge clk);
            while (txd_out !== 1'b1) @(negedge clk);
            chk("R10 shift out bit", {7'd0, rxd_out}, {7'd0, 8'hC3 >> i} & 8'd1);
            chk("R10 drive enable", {7'd0, rxd_oe}, 8'd1);
        end
        repeat (4) @(negedge clk);
        rd_chk(1'b0, 8'h02, "R10 TI after shift");

        // R11 mode 0 receive
        wr(1'b0, 8'h10);
        for (int i = 0; i < 8; i++) begin
            while (txd_out !== 1'b0) @(negedge clk);
            rxd_in = (8'h5B >> i) & 8'd1;
            while (txd_out !== 1'b1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rxd_in = 1'b1;
        rd_chk(1'b0, 8'h11, "R11 RI after shift in");
        rd_chk(1'b1, 8'h5B, "R11 data shift in");
        chk("R11 R12 irq", {7'd0, irq}, 8'd1);

        finish_run();
    end
endmodule